// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds several physical copies of one register, all answering at a single bus offset, one copy per hardware unit. The units are organised as slices, each with a fixed number of subslices. A second offset on the same bus holds a selector register. The selector carries a slice number, a subslice number and a broadcast flag. Together these decide which copy a bus access reaches.

A write with the broadcast flag set is fanned out to every copy. With the flag clear, the write reaches only the copy the selector points at. A read always returns exactly one copy, the one the selector points at, and ignores the broadcast flag.

An availability vector, supplied as a plain input, marks copies whose unit is fused off or powered down. An access steered to an unavailable copy is terminated: a read returns zero and a single-copy write is dropped. A selector pointing past the last slice or subslice counts as unavailable. The bus takes one request per cycle and answers with a registered response one cycle later. A two-state machine sequences that response: `ST_IDLE` and `ST_RESP`. The transitions are *accept* (ST_IDLE to ST_RESP on a valid request), *chain* (ST_RESP to ST_RESP on a back-to-back request), *drain* (ST_RESP to ST_IDLE with no request) and *wait* (ST_IDLE to ST_IDLE).

Top module: `steered_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (broadcast set, slice 0, subslice 0), every copy holds zero, and rsp_valid_o is low.
- R2: Every cycle with req_valid_i high produces rsp_valid_o high in the following cycle, and only then. Read data arrives with that response. Write responses carry zero data.
- R3: The selector holds the subslice number in bits [3:0], the slice number in bits [11:8] and the broadcast flag in bit 31. Writes set all three fields, and a read returns them with every other bit zero.
- R4: A bank write with the broadcast flag set stores the write data into every copy whose availability bit is 1.
- R5: A broadcast bank write leaves each copy whose availability bit is 0 unchanged.
- R6: A bank write with the broadcast flag clear stores only into copy slice*SUBSLICES_PER_SLICE+subslice. All other copies stay unchanged.
- R7: A single-copy bank write steered to a copy whose availability bit is 0 is dropped.
- R8: A bank read returns the steered copy whatever the value of the broadcast flag.
- R9: A bank read steered to a copy whose availability bit is 0 returns zero.
- R10: A selector with subslice >= SUBSLICES_PER_SLICE or slice >= NUM_SLICES is treated as unavailable: reads return zero and single-copy writes are dropped.
- R11: A read from any offset other than the bank or the selector returns zero, and a write there changes neither the copies nor the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avail_i | input | NUM_SLICES*SUBSLICES_PER_SLICE | Per-copy availability, bit i for copy i, 1 = present |
| req_valid_i | input | 1 | Bus request strobe, one access per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | DATA_W | Registered read data |

## Verification
The bench drives a slice/subslice value that would alias onto a real copy if the range check were missing (subslice 5 with four subslices per slice). A design that indexed without the check would return or overwrite copy 5 instead of terminating. It sends broadcast writes with gaps in the availability vector, which a design that ignored availability on broadcast would fill. It sends single-copy writes and reads to gated copies, where a wrong design would store the data or return a stale nonzero value. It reads with the broadcast flag both set and clear, to catch a read path that honoured the flag. It also checks masked selector read-back, stray-offset accesses and response timing over back-to-back and idle cycles.

// File: rtl/steered_bank_pkg.sv
package steered_bank_pkg;

    // Selector field layout (bit positions are part of the bus contract)
    localparam int SEL_SUB_LSB   = 0;
    localparam int SEL_SLICE_LSB = 8;
    localparam int SEL_FIELD_W   = 4;
    localparam int SEL_BCAST_BIT = 31;

    typedef struct packed {
        logic                   bcast;
        logic [SEL_FIELD_W-1:0] slice;
        logic [SEL_FIELD_W-1:0] sub;
    } sel_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/sb_selector.sv
module sb_selector
    import steered_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output sel_t              sel_q,
    output logic [DATA_W-1:0] sel_image
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q.bcast <= 1'b1;
            sel_q.slice <= '0;
            sel_q.sub   <= '0;
        end else if (wr_en) begin
            sel_q.bcast <= wr_data[SEL_BCAST_BIT];
            sel_q.slice <= wr_data[SEL_SLICE_LSB +: SEL_FIELD_W];
            sel_q.sub   <= wr_data[SEL_SUB_LSB +: SEL_FIELD_W];
        end
    end

    always_comb begin
        sel_image                                  = '0;
        sel_image[SEL_BCAST_BIT]                   = sel_q.bcast;
        sel_image[SEL_SLICE_LSB +: SEL_FIELD_W]    = sel_q.slice;
        sel_image[SEL_SUB_LSB +: SEL_FIELD_W]      = sel_q.sub;
    end

endmodule

// File: rtl/sb_store.sv
module sb_store #(
    parameter int NUM_COPIES = 8,
    parameter int DATA_W     = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_COPIES-1:0]              wen,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_COPIES-1:0][DATA_W-1:0]  copies_q
);

    for (genvar i = 0; i < NUM_COPIES; i++) begin : g_copy
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                copies_q[i] <= '0;
            end else if (wen[i]) begin
                copies_q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/sb_route.sv
module sb_route
    import steered_bank_pkg::*;
#(
    parameter int NUM_SLICES          = 2,
    parameter int SUBSLICES_PER_SLICE = 4,
    parameter int DATA_W              = 32,
    localparam int NUM_COPIES         = NUM_SLICES * SUBSLICES_PER_SLICE,
    localparam int IDX_W              = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  sel_t                               sel,
    input  logic [NUM_COPIES-1:0]              avail,
    input  logic                               bank_we,
    input  logic [NUM_COPIES-1:0][DATA_W-1:0]  copies,
    output logic [NUM_COPIES-1:0]              wen,
    output logic                               rd_hit,
    output logic [DATA_W-1:0]                  rd_data
);

    logic             in_range;
    logic [IDX_W-1:0] idx;
    int               full_idx;

    always_comb begin
        in_range = (int'(sel.slice) < NUM_SLICES) &&
                   (int'(sel.sub)   < SUBSLICES_PER_SLICE);
        full_idx = int'(sel.slice) * SUBSLICES_PER_SLICE + int'(sel.sub);
        idx      = in_range ? IDX_W'(full_idx) : '0;
        rd_hit   = in_range && avail[idx];
        rd_data  = rd_hit ? copies[idx] : '0;
    end

    for (genvar i = 0; i < NUM_COPIES; i++) begin : g_wen
        always_comb begin
            wen[i] = bank_we && avail[i] &&
                     (sel.bcast || (in_range && (int'(idx) == i)));
        end

        // R5 / R7: a copy whose unit is absent keeps its value across any bank write
        p_gated_copy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_we && !avail[i]) |=> $stable(copies[i]))
            else $error("gated copy %0d changed", i);
    end

    // R6: a single-copy write reaches at most one copy
    p_unicast_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && !sel.bcast) |-> $onehot0(wen))
        else $error("single-copy write enabled several copies");

    // R10: an out-of-range selector never reaches a copy on a single-copy write
    p_range_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && !sel.bcast && !in_range) |=> $stable(copies))
        else $error("out-of-range write changed a copy");

endmodule

// File: rtl/steered_bank.sv
module steered_bank
    import steered_bank_pkg::*;
#(
    parameter int              NUM_SLICES          = 2,
    parameter int              SUBSLICES_PER_SLICE = 4,
    parameter int              DATA_W              = 32,
    parameter int              ADDR_W              = 12,
    parameter logic [ADDR_W-1:0] BANK_OFFSET       = 12'h100,
    parameter logic [ADDR_W-1:0] SEL_OFFSET        = 12'h104
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_SLICES*SUBSLICES_PER_SLICE-1:0]    avail_i,
    input  logic                                         req_valid_i,
    input  logic                                         req_write_i,
    input  logic [ADDR_W-1:0]                            req_addr_i,
    input  logic [DATA_W-1:0]                            req_wdata_i,
    output logic                                         rsp_valid_o,
    output logic [DATA_W-1:0]                            rsp_rdata_o
);

    localparam int NUM_COPIES = NUM_SLICES * SUBSLICES_PER_SLICE;

    bus_state_e                           state_q, state_d;
    sel_t                                 sel_q;
    logic [DATA_W-1:0]                    sel_image;
    logic [NUM_COPIES-1:0][DATA_W-1:0]    copies;
    logic [NUM_COPIES-1:0]                wen;
    logic                                 rd_hit;
    logic [DATA_W-1:0]                    bank_rd;
    logic                                 hit_bank, hit_sel;
    logic                                 bank_we, sel_we;
    logic [DATA_W-1:0]                    rdata_d, rdata_q;

    always_comb begin
        hit_bank = (req_addr_i == BANK_OFFSET);
        hit_sel  = (req_addr_i == SEL_OFFSET);
        bank_we  = req_valid_i && req_write_i && hit_bank;
        sel_we   = req_valid_i && req_write_i && hit_sel;
    end

    sb_selector #(.DATA_W(DATA_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sel_we),
        .wr_data   (req_wdata_i),
        .sel_q     (sel_q),
        .sel_image (sel_image)
    );

    sb_route #(
        .NUM_SLICES          (NUM_SLICES),
        .SUBSLICES_PER_SLICE (SUBSLICES_PER_SLICE),
        .DATA_W              (DATA_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .avail   (avail_i),
        .bank_we (bank_we),
        .copies  (copies),
        .wen     (wen),
        .rd_hit  (rd_hit),
        .rd_data (bank_rd)
    );

    sb_store #(.NUM_COPIES(NUM_COPIES), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (wen),
        .wdata    (req_wdata_i),
        .copies_q (copies)
    );

    // Next-state logic: accept / chain / drain / wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Read data selection for the accepted request
    always_comb begin
        rdata_d = '0;
        if (req_valid_i && !req_write_i) begin
            if (hit_bank)     rdata_d = bank_rd;
            else if (hit_sel) rdata_d = sel_image;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           rdata_q <= '0;
        else if (req_valid_i) rdata_q <= rdata_d;
    end

    // Output process
    always_comb begin
        rsp_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: rsp_valid_o = 1'b0;
            ST_RESP: rsp_valid_o = 1'b1;
            default: rsp_valid_o = 1'b0;
        endcase
        rsp_rdata_o = rdata_q;
    end

    // R2: a response follows every request by exactly one cycle
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o)
        else $error("missing response");
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o)
        else $error("response without request");

    // R9: a terminated bank read answers zero
    p_gated_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && hit_bank && !rd_hit) |=> (rsp_rdata_o == '0))
        else $error("terminated read returned data");

    // R11: a stray offset reads zero
    p_stray_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && !hit_bank && !hit_sel) |=> (rsp_rdata_o == '0))
        else $error("stray offset returned data");

    // R3: selector read-back has no bits outside its fields
    p_sel_image_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && hit_sel) |=>
        ((rsp_rdata_o & ~(32'h8000_0F0F)) == '0))
        else $error("selector read-back has stray bits");

endmodule

// File: tb/steered_bank_tb_top.sv
module steered_bank_tb_top;

    localparam int NS   = 2;
    localparam int SPS  = 4;
    localparam int NC   = NS * SPS;
    localparam logic [11:0] BANK = 12'h100;
    localparam logic [11:0] SEL  = 12'h104;
    localparam logic [11:0] STRAY = 12'h0F8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] avail_i;
    logic          req_valid_i, req_write_i;
    logic [11:0]   req_addr_i;
    logic [31:0]   req_wdata_i;
    logic          rsp_valid_o;
    logic [31:0]   rsp_rdata_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [31:0] model [NC];
    logic        m_bcast;
    logic [3:0]  m_slice, m_sub;

    always #5 clk = ~clk;

    steered_bank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .avail_i     (avail_i),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

    function automatic bit m_hit(input logic [NC-1:0] av);
        int ix;
        if (int'(m_slice) >= NS || int'(m_sub) >= SPS) return 1'b0;
        ix = int'(m_slice) * SPS + int'(m_sub);
        return av[ix];
    endfunction

    function automatic int m_idx();
        return int'(m_slice) * SPS + int'(m_sub);
    endfunction

    task automatic check(input string tag, input logic v, input logic [31:0] d,
                         input logic ev, input logic [31:0] ed);
        vectors++;
        if (v !== ev || (ev && d !== ed)) begin
            miscompares++;
            $display("FAIL %s: rsp_valid=%0b rdata=%h expected valid=%0b rdata=%h",
                     tag, v, d, ev, ed);
        end
    endtask

    // One bus cycle: drive at negedge, update the model, compare after the edge
    task automatic access(input logic v, input logic w, input logic [11:0] a,
                          input logic [31:0] d, input logic [NC-1:0] av,
                          input string tag);
        logic [31:0] exp_d;
        @(negedge clk);
        req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = d;
        avail_i = av;
        exp_d = '0;
        if (v && !w) begin
            if (a == BANK)     exp_d = m_hit(av) ? model[m_idx()] : 32'h0;
            else if (a == SEL) exp_d = {m_bcast, 19'h0, m_slice, 4'h0, m_sub};
        end
        if (v && w) begin
            if (a == BANK) begin
                if (m_bcast) begin
                    for (int i = 0; i < NC; i++) if (av[i]) model[i] = d;
                end else if (m_hit(av)) begin
                    model[m_idx()] = d;
                end
            end else if (a == SEL) begin
                m_bcast = d[31]; m_slice = d[11:8]; m_sub = d[3:0];
            end
        end
        @(posedge clk);
        #1;
        check(tag, rsp_valid_o, rsp_rdata_o, v, exp_d);
    endtask

    function automatic logic [31:0] selw(input bit bc, input int sl, input int ss);
        return {bc, 19'h0, 4'(sl), 4'h0, 4'(ss)};
    endfunction

    task automatic read_all(input bit bc, input logic [NC-1:0] av, input string tag);
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < SPS; b++) begin
                access(1, 1, SEL, selw(bc, s, b), av, tag);
                access(1, 0, BANK, 32'h0, av, tag);
            end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NC; i++) model[i] = '0;
        m_bcast = 1'b1; m_slice = '0; m_sub = '0;
        rst_n = 1'b0; avail_i = '1;
        req_valid_i = 0; req_write_i = 0; req_addr_i = '0; req_wdata_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 reset rsp_valid", rsp_valid_o, rsp_rdata_o, 1'b0, 32'h0);
        access(1, 0, SEL,  32'h0, '1, "R1 selector reset value");
        access(1, 0, BANK, 32'h0, '1, "R1 copy reset value");
        access(0, 0, BANK, 32'h0, '1, "R2 idle no response");
        read_all(1'b0, '1, "R1 all copies zero");

        // Broadcast with holes in the availability vector
        access(1, 1, SEL, selw(1, 0, 0), '1, "R3 set broadcast");
        access(1, 1, BANK, 32'hA5A5_0001, 8'b1011_0110, "R4 broadcast write");
        read_all(1'b0, '1, "R5 broadcast skips gated copies");

        // Single-copy writes, distinct per copy
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < SPS; b++) begin
                access(1, 1, SEL, selw(0, s, b), '1, "R6 steer");
                access(1, 1, BANK, 32'hC000_0000 | (s << 8) | b, '1, "R6 single-copy write");
            end
        read_all(1'b0, '1, "R6 readback unicast");
        read_all(1'b1, '1, "R8 readback with broadcast flag set");

        // Gated single-copy write and gated read
        access(1, 1, SEL, selw(0, 1, 2), '1, "R7 steer to copy 6");
        access(1, 1, BANK, 32'hDEAD_BEEF, 8'b1011_1111, "R7 write to gated copy");
        access(1, 0, BANK, 32'h0, 8'b1011_1111, "R9 read gated copy");
        access(1, 0, BANK, 32'h0, '1, "R7 copy 6 unchanged");

        // Out-of-range steering that would alias onto real copies
        access(1, 1, SEL, selw(0, 0, 5), '1, "R10 subslice out of range");
        access(1, 1, BANK, 32'h1234_5678, '1, "R10 write dropped");
        access(1, 0, BANK, 32'h0, '1, "R10 read zero");
        access(1, 1, SEL, selw(0, 2, 1), '1, "R10 slice out of range");
        access(1, 0, BANK, 32'h0, '1, "R10 read zero slice");
        read_all(1'b0, '1, "R10 copies intact");

        // Selector masking and stray offset
        access(1, 1, SEL, 32'h7FFF_F0F0 | 32'h0000_0103, '1, "R3 write with junk bits");
        access(1, 0, SEL, 32'h0, '1, "R3 masked readback");
        access(1, 1, STRAY, 32'hFFFF_FFFF, '1, "R11 stray write");
        access(1, 0, STRAY, 32'h0, '1, "R11 stray read zero");
        access(1, 0, SEL, 32'h0, '1, "R11 selector unchanged");
        read_all(1'b0, '1, "R11 copies unchanged");

        // Mixed traffic with idle gaps and shifting availability
        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom;
            logic [NC-1:0] av = NC'($urandom);
            case (r % 5)
                0: access(1, 1, SEL, selw(r[8], int'(r[10:9]), int'(r[13:11])), av, "R6 mixed steer");
                1: access(1, 1, BANK, $urandom, av, "R4 mixed write");
                2: access(1, 0, BANK, 32'h0, av, "R8 mixed read");
                3: access(1, 0, SEL, 32'h0, av, "R3 mixed selector read");
                default: access(0, 0, BANK, 32'h0, av, "R2 mixed idle");
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule